// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block holds two 16-bit count channels that share one 8-bit mode byte. Each channel counts either machine cycles or falling edges on its own external count input. A machine cycle is one tick every twelve system clocks, produced by an internal divider. Counting depends on a per-channel run bit. A gate-enable bit in the mode byte can also make counting depend on an external gate pin.

Each channel has four counting layouts:
- a 13-bit count with a 5-bit prescaler;
- a plain 16-bit count;
- an 8-bit count that reloads from the upper byte;
- a split layout, in which channel 0 acts as two independent 8-bit counters and channel 1 freezes.

When a channel's active width rolls over, it raises a sticky overflow flag. The flag stays set until it is cleared from the clear input. Software writes the mode byte and can preload either count. External count and gate inputs pass through a synchroniser. Count inputs are then compared from one machine cycle to the next, so a level must last at least one machine cycle to be seen.

Top module: `twin_timer_counter`

## Requirements
- R1: While reset is held, and on the cycle after it, both counts, both overflow flags and the mode byte read as zero.
- R2: Writing the mode byte changes the readback on the next cycle. Bits [7:4] configure channel 1 and bits [3:0] configure channel 0. Within a nibble: bit 3 is gate-enable, bit 2 selects event counting (1) or machine-cycle counting (0), and bits [1:0] are the layout.
- R3: In machine-cycle counting, while a channel is enabled, its count advances by exactly one for every 12 system clocks.
- R4: A channel whose run bit is 0 keeps its count.
- R5: With gate-enable set, a channel counts only while its synchronised gate pin is high. With gate-enable clear, the gate pin has no effect.
- R6: In event counting, the count advances once for each falling edge on the count input, provided each level lasts at least one machine cycle. A rising edge does not count.
- R7: Layout 01 counts over all 16 bits. It wraps from 0xFFFF to 0x0000 and sets the channel's overflow flag.
- R8: Layout 00 counts a 13-bit value made of the upper byte over bits [4:0] of the lower byte. It wraps from 0x1FFF to zero and sets the flag. Bits [7:5] of the lower byte are left unchanged.
- R9: Layout 10 advances the lower byte only. From 0xFF it reloads from the upper byte and sets the flag. The upper byte is never changed by counting.
- R10: With channel 0 in layout 11:
  - Channel 0's lower byte counts under channel 0's own controls and sets flag 0 when it wraps.
  - Channel 0's upper byte counts machine cycles while run bit 1 is set, and its wrap sets flag 1.
  - Channel 1 in layout 11 holds its count.
- R11: A load strobe writes the supplied value into the channel's count on the next cycle. A load takes priority over counting.
- R12: An overflow flag stays set until its clear bit is pulsed. Clearing one flag leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we_i | input | 1 | Mode byte write strobe |
| mode_wdata_i | input | 8 | Mode byte write data |
| mode_rdata_o | output | 8 | Current mode byte |
| run_i | input | 2 | Per-channel run bits |
| cnt_in_i | input | 2 | External count inputs (asynchronous) |
| gate_in_i | input | 2 | External gate inputs (asynchronous) |
| load_we_i | input | 2 | Per-channel count load strobes |
| load_val0_i | input | 16 | Load value for channel 0 |
| load_val1_i | input | 16 | Load value for channel 1 |
| count0_o | output | 16 | Channel 0 count |
| count1_o | output | 16 | Channel 1 count |
| ovf_o | output | 2 | Sticky overflow flags |
| ovf_clr_i | input | 2 | Overflow flag clear strobes |

## Verification
The assertions check the following on every clock:
- a halted channel's lower byte stays put;
- loads land exactly one cycle after the strobe;
- layout 01 never steps by more than one per cycle;
- the upper byte in reload layout and a frozen channel 1 in split layout both stay stable;
- flags stay set until cleared;
- the mode byte tracks its writes.

Other behaviour can only be shown by the bench's scenarios:
- exact tick counts over a window of twelve clocks;
- the way the prescaled 13-bit layout and the reload layout behave across rollover;
- flag ownership in split layout;
- gate qualification through the synchroniser;
- edge counting on a slow external input, including the check that rising edges are ignored.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    M_PRESCALE = 2'b00,
    M_FULL     = 2'b01,
    M_RELOAD   = 2'b10,
    M_SPLIT    = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     gate_en;
    logic     ext_evt;
    tc_mode_e mode;
  } tc_cfg_t;

endpackage

// File: rtl/tc_tick_gen.sv
module tc_tick_gen #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (pcnt_q == PW'(DIV - 1));
      pcnt_q <= (pcnt_q == PW'(DIV - 1)) ? '0 : pcnt_q + PW'(1);
    end
  end
endmodule

// File: rtl/tc_in_sync.sv
module tc_in_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= '0;
    else     stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  if (EDGE) begin : g_fall
    logic [W-1:0] samp_q;
    always_ff @(posedge clk) begin
      if (rst)         samp_q <= '0;
      else if (tick_i) samp_q <= stg_q[STAGES-1];
    end
    assign ev_o = {W{tick_i}} & samp_q & ~stg_q[STAGES-1];
  end else begin : g_level
    assign ev_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/tc_chan.sv
module tc_chan
  import tc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit HAS_SPLIT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  tc_mode_e            mode_i,
  input  logic                step_lo_i,
  input  logic                step_hi_i,
  input  logic                ld_we_i,
  input  logic [2*BYTE_W-1:0] ld_val_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                wrap_lo_o,
  output logic                wrap_hi_o
);
  localparam int CW  = 2 * BYTE_W;
  localparam int PCW = BYTE_W + PRE_W;

  logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic [PCW-1:0]    v13;
  logic [CW-1:0]     v16;

  always_comb begin
    hi_d      = hi_q;
    lo_d      = lo_q;
    wrap_lo_o = 1'b0;
    wrap_hi_o = 1'b0;
    v13       = {hi_q, lo_q[PRE_W-1:0]} + PCW'(1);
    v16       = {hi_q, lo_q} + CW'(1);
    case (mode_i)
      M_PRESCALE: if (step_lo_i) begin
        hi_d      = v13[PCW-1:PRE_W];
        lo_d      = {lo_q[BYTE_W-1:PRE_W], v13[PRE_W-1:0]};
        wrap_lo_o = &{hi_q, lo_q[PRE_W-1:0]};
      end
      M_FULL: if (step_lo_i) begin
        {hi_d, lo_d} = v16;
        wrap_lo_o    = &{hi_q, lo_q};
      end
      M_RELOAD: if (step_lo_i) begin
        if (&lo_q) begin
          lo_d      = hi_q;
          wrap_lo_o = 1'b1;
        end else begin
          lo_d = lo_q + BYTE_W'(1);
        end
      end
      M_SPLIT: if (HAS_SPLIT) begin
        if (step_lo_i) begin
          lo_d      = lo_q + BYTE_W'(1);
          wrap_lo_o = &lo_q;
        end
        if (step_hi_i) begin
          hi_d      = hi_q + BYTE_W'(1);
          wrap_hi_o = &hi_q;
        end
      end
    endcase
    if (ld_we_i) begin
      {hi_d, lo_d} = ld_val_i;
      wrap_lo_o    = 1'b0;
      wrap_hi_o    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign cnt_o = {hi_q, lo_q};
endmodule

// File: rtl/twin_timer_counter.sv
module twin_timer_counter
  import tc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int DIV         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_we_i,
  input  logic [7:0]          mode_wdata_i,
  output logic [7:0]          mode_rdata_o,
  input  logic [1:0]          run_i,
  input  logic [1:0]          cnt_in_i,
  input  logic [1:0]          gate_in_i,
  input  logic [1:0]          load_we_i,
  input  logic [2*BYTE_W-1:0] load_val0_i,
  input  logic [2*BYTE_W-1:0] load_val1_i,
  output logic [2*BYTE_W-1:0] count0_o,
  output logic [2*BYTE_W-1:0] count1_o,
  output logic [1:0]          ovf_o,
  input  logic [1:0]          ovf_clr_i
);
  localparam int CW  = 2 * BYTE_W;
  localparam int NCH = 2;

  logic [7:0]     mode_q;
  logic           tick;
  logic [NCH-1:0] fall, gate_lvl, step, wrap_lo, wrap_hi, flag_set;
  logic [CW-1:0]  cnt_w  [NCH];
  logic [CW-1:0]  load_w [NCH];
  tc_cfg_t        cfg    [NCH];

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end
  assign mode_rdata_o = mode_q;

  tc_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  tc_in_sync #(.W(NCH), .STAGES(SYNC_STAGES), .EDGE(1'b1)) u_cnt_sync (
    .clk(clk), .rst(rst), .tick_i(tick), .async_i(cnt_in_i), .ev_o(fall)
  );

  tc_in_sync #(.W(NCH), .STAGES(SYNC_STAGES), .EDGE(1'b0)) u_gate_sync (
    .clk(clk), .rst(rst), .tick_i(tick), .async_i(gate_in_i), .ev_o(gate_lvl)
  );

  assign load_w[0] = load_val0_i;
  assign load_w[1] = load_val1_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg[i]  = tc_cfg_t'(mode_q[4*i +: 4]);
    assign step[i] = tick & run_i[i] & (~cfg[i].gate_en | gate_lvl[i]) &
                     (~cfg[i].ext_evt | fall[i]);

    tc_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .HAS_SPLIT(i == 0)) u_chan (
      .clk(clk), .rst(rst), .mode_i(cfg[i].mode),
      .step_lo_i(step[i]),
      .step_hi_i((i == 0) ? (tick & run_i[1]) : 1'b0),
      .ld_we_i(load_we_i[i]), .ld_val_i(load_w[i]),
      .cnt_o(cnt_w[i]), .wrap_lo_o(wrap_lo[i]), .wrap_hi_o(wrap_hi[i])
    );
  end

  // In split layout, channel 0's upper byte takes over flag 1.
  assign flag_set[0] = wrap_lo[0];
  assign flag_set[1] = (cfg[0].mode == M_SPLIT) ? wrap_hi[0] : (wrap_lo[1] | wrap_hi[1]);

  always_ff @(posedge clk) begin
    if (rst) ovf_o <= '0;
    else     ovf_o <= (ovf_o & ~ovf_clr_i) | flag_set;
  end

  assign count0_o = cnt_w[0];
  assign count1_o = cnt_w[1];
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_we_i,
  input logic [7:0]    mode_wdata_i,
  input logic [7:0]    mode_rdata_o,
  input logic [1:0]    run_i,
  input logic [1:0]    load_we_i,
  input logic [CW-1:0] load_val0_i,
  input logic [CW-1:0] load_val1_i,
  input logic [CW-1:0] count0_o,
  input logic [CW-1:0] count1_o,
  input logic [1:0]    ovf_o,
  input logic [1:0]    ovf_clr_i
);
  localparam int HB = CW / 2;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (count0_o == '0 && count1_o == '0 && ovf_o == 2'b00 && mode_rdata_o == 8'h00));

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (rst)
    mode_we_i |=> mode_rdata_o == $past(mode_wdata_i));

  // R4
  halted_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i[0] && !load_we_i[0]) |=> $stable(count0_o[HB-1:0]));

  // R7
  full_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_rdata_o[1:0] == 2'b01 && !load_we_i[0]) |=>
      (count0_o == $past(count0_o) || count0_o == $past(count0_o) + CW'(1)));

  // R9
  reload_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_rdata_o[1:0] == 2'b10 && !load_we_i[0]) |=> $stable(count0_o[CW-1:HB]));

  // R10
  frozen_ch1_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_rdata_o[5:4] == 2'b11 && !load_we_i[1]) |=> $stable(count1_o));

  // R11
  load0_chk: assert property (@(posedge clk) disable iff (rst)
    load_we_i[0] |=> count0_o == $past(load_val0_i));

  // R11
  load1_chk: assert property (@(posedge clk) disable iff (rst)
    load_we_i[1] |=> count1_o == $past(load_val1_i));

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o[0] && !ovf_clr_i[0]) |=> ovf_o[0]);
endmodule

bind twin_timer_counter tc_checker #(.CW(2*BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
  .mode_rdata_o(mode_rdata_o), .run_i(run_i), .load_we_i(load_we_i),
  .load_val0_i(load_val0_i), .load_val1_i(load_val1_i),
  .count0_o(count0_o), .count1_o(count1_o), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
);

// File: tb/twin_timer_counter_tb.sv
module twin_timer_counter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic [7:0]  mode_rdata;
  logic [1:0]  run = '0, cnt_in = '0, gate_in = '0, load_we = '0, ovf_clr = '0;
  logic [15:0] load_val0 = '0, load_val1 = '0, count0, count1;
  logic [1:0]  ovf;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twin_timer_counter u_dut (
    .clk(clk), .rst(rst), .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .mode_rdata_o(mode_rdata), .run_i(run), .cnt_in_i(cnt_in), .gate_in_i(gate_in),
    .load_we_i(load_we), .load_val0_i(load_val0), .load_val1_i(load_val1),
    .count0_o(count0), .count1_o(count1), .ovf_o(ovf), .ovf_clr_i(ovf_clr)
  );

  typedef struct packed {
    logic [7:0]  cfg;
    logic [1:0]  run;
    logic [1:0]  gate;
    logic [15:0] ld0;
    logic [15:0] ld1;
    logic [7:0]  n;
    logic [15:0] exp0;
    logic [15:0] exp1;
    logic [1:0]  eovf;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h11, 2'b11, 2'b00, 16'h0000, 16'h1000, 8'd5, 16'h0005, 16'h1005, 2'b00}, // R3 R5
    '{8'h11, 2'b01, 2'b00, 16'h0010, 16'h0020, 8'd4, 16'h0014, 16'h0020, 2'b00}, // R4
    '{8'h11, 2'b11, 2'b00, 16'hFFFE, 16'hFFFD, 8'd3, 16'h0001, 16'h0000, 2'b11}, // R7
    '{8'h00, 2'b11, 2'b00, 16'h12FE, 16'hFFFF, 8'd3, 16'h13E1, 16'h00E2, 2'b10}, // R8
    '{8'h22, 2'b11, 2'b00, 16'h40FE, 16'h8010, 8'd4, 16'h4042, 16'h8014, 2'b01}, // R9
    '{8'h99, 2'b11, 2'b01, 16'h0100, 16'h0200, 8'd6, 16'h0106, 16'h0200, 2'b00}, // R5
    '{8'h33, 2'b11, 2'b00, 16'hFEFD, 16'h1234, 8'd3, 16'h0100, 16'h1234, 2'b11}, // R10
    '{8'h33, 2'b10, 2'b00, 16'h0505, 16'h0606, 8'd2, 16'h0705, 16'h0606, 2'b00}  // R10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [7:0] c, input logic [1:0] g,
                       input logic [15:0] v0, input logic [15:0] v1);
    @(negedge clk);
    run = 2'b00; mode_we = 1'b1; mode_wdata = c; gate_in = g;
    load_we = 2'b11; load_val0 = v0; load_val1 = v1; ovf_clr = 2'b11;
    @(negedge clk);
    mode_we = 1'b0; load_we = 2'b00; ovf_clr = 2'b00;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 count0", count0, 16'h0);
    chk("R1 count1", count1, 16'h0);
    chk("R1 ovf", {14'd0, ovf}, 16'h0);
    chk("R1 mode", {8'd0, mode_rdata}, 16'h0);

    // R2
    mode_we = 1'b1; mode_wdata = 8'hA5;
    @(negedge clk);
    mode_we = 1'b0;
    chk("R2 readback", {8'd0, mode_rdata}, 16'h00A5);

    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].cfg, VECS[i].gate, VECS[i].ld0, VECS[i].ld1);
      run = VECS[i].run;
      repeat (12 * int'(VECS[i].n)) @(posedge clk);
      @(negedge clk);
      run = 2'b00;
      repeat (2) @(negedge clk);
      chk($sformatf("vec%0d count0", i), count0, VECS[i].exp0);
      chk($sformatf("vec%0d count1", i), count1, VECS[i].exp1);
      chk($sformatf("vec%0d ovf", i), {14'd0, ovf}, {14'd0, VECS[i].eovf});
    end

    // R6 event counting on channel 0, layout 01
    setup(8'h05, 2'b00, 16'h0000, 16'h0000);
    cnt_in = 2'b00;
    run = 2'b01;
    for (int p = 0; p < 7; p++) begin
      cnt_in[0] = 1'b1;
      repeat (24) @(negedge clk);
      cnt_in[0] = 1'b0;
      repeat (24) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk("R6 seven falls", count0, 16'd7);
    cnt_in[0] = 1'b1;
    repeat (60) @(negedge clk);
    chk("R6 rise ignored", count0, 16'd7);
    cnt_in[0] = 1'b0;
    repeat (60) @(negedge clk);
    chk("R6 eighth fall", count0, 16'd8);
    run = 2'b00;

    // R11 load held across ticks wins over counting
    setup(8'h11, 2'b00, 16'h0000, 16'h0000);
    run = 2'b01; load_we = 2'b01; load_val0 = 16'h5555;
    repeat (30) @(negedge clk);
    chk("R11 load priority", count0, 16'h5555);
    load_we = 2'b00; run = 2'b00;

    // R12 sticky flag and independent clear
    setup(8'h11, 2'b00, 16'hFFFF, 16'hFFFF);
    run = 2'b11;
    repeat (12) @(posedge clk);
    @(negedge clk);
    run = 2'b00;
    repeat (40) @(negedge clk);
    chk("R12 sticky", {14'd0, ovf}, 16'h0003);
    ovf_clr = 2'b01;
    @(negedge clk);
    ovf_clr = 2'b00;
    @(negedge clk);
    chk("R12 clear ch0", {15'd0, ovf[0]}, 16'h0);
    chk("R12 ch1 kept", {15'd0, ovf[1]}, 16'h1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule